// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver

This block turns an asynchronous serial line into bytes. The line rests high. A frame opens with a low start bit. Five to eight data bits follow, least significant first. An optional parity bit comes next, and the frame closes with one or two high stop bits. A divisor-driven tick runs at sixteen times the bit rate. The receiver restarts that tick on each start edge, so bit timing never carries over from one frame to the next. Each bit is decided by a majority vote over the three samples nearest its centre.

Each finished byte goes into a holding register. A valid flag marks it, and the byte's own parity and framing status travel with it. A one-cycle read acknowledge empties the register. A byte that finishes while the register still holds an unread one sets a sticky overrun flag. After traffic stops, the block gives a single idle pulse once the line has stayed quiet for a full frame time. A consumer can use that pulse to close a variable-length message.

Top module: `uart_os_rx`

## Requirements
- R1: The sampling tick repeats every `cfg_div`+1 clock cycles, and one bit lasts 16 ticks. Bytes sent at that bit period are received correctly for every divisor value.
- R2: The line passes through a two-flop synchroniser, and a falling edge seen while idle starts a frame. If the start bit votes high at its centre, the edge is treated as a glitch: no byte is delivered, and the receiver returns to idle and waits for the next edge.
- R3: `cfg_bits` selects the word length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits are taken least significant first. The byte appears right-aligned on `rx_data`, with the unused upper bits zero.
- R4: Each bit value is the majority of the samples at ticks 7, 8 and 9 of that bit. A disturbance that reaches only one of those samples does not change the received value.
- R5: When `cfg_par_en` is 1, a parity bit follows the data. With `cfg_par_odd`=0 the count of ones over data and parity must be even; with 1 it must be odd. A mismatch sets `parity_err` with the byte. With parity off, `parity_err` stays 0.
- R6: `cfg_two_stop` selects one (0) or two (1) stop bits. If any stop bit votes low, `frame_err` is set. The byte is still delivered.
- R7: The cycle after a byte completes, `rx_valid` is 1 and the data and error flags are held. A one-cycle `rd_ack` clears `rx_valid`, `frame_err`, `parity_err` and `overrun` by the next cycle.
- R8: A byte that completes while `rx_valid` is 1 and no `rd_ack` is present sets `overrun`. The newer byte replaces the held one. `overrun` stays set until `rd_ack`.
- R9: `idle_pulse` is a single-cycle pulse. It is raised when the receiver is idle and the line has been high for a full frame time: 16 × (start + data + parity + stop bits) ticks. This happens only after at least one byte has been received since the last pulse.
- R10: Frames that follow one another after a gap of any length, with no whole-bit alignment, are each received correctly, because timing is re-taken from each start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| cfg_div | input | DIV_W | Tick divisor; tick period is cfg_div+1 clocks |
| cfg_bits | input | 2 | Word length select, 5 + value bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_two_stop | input | 1 | 1 = two stop bits, 0 = one |
| rd_ack | input | 1 | Read acknowledge, empties the holding register |
| rx_data | output | DW | Received byte, right-aligned |
| rx_valid | output | 1 | Holding register contains an unread byte |
| frame_err | output | 1 | Held byte had a low stop bit |
| parity_err | output | 1 | Held byte failed its parity check |
| overrun | output | 1 | A byte was replaced before it was read |
| idle_pulse | output | 1 | One-cycle line-idle event |

## Verification
The bench sends a short low pulse that only resembles a start bit. A receiver that skipped the centre re-check would report a spurious byte and arm the idle event. Single-sample disturbances at each bit centre catch a receiver that uses one sample rather than the vote. Frames with a low final stop bit or a flipped parity bit must still be delivered, with only the matching flag set. Two frames with no read between them must leave the newest byte and a sticky overrun. The idle pulse is checked on both sides of its deadline, one bit time early and one bit time late, with a gap of unaligned length between consecutive frames. A receiver that counted from the wrong point, or that fired without a prior byte, fails at one of those two points.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int OS  = 16;  // samples per bit
  localparam int MID = 8;   // tick index of the third centre sample

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;

  // majority of three samples
  function automatic logic vote3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction

  // data bits per word for a length code
  function automatic int unsigned word_len(input logic [1:0] sel);
    return 32'd5 + {30'd0, sel};
  endfunction

  // ticks in a whole frame: start, data, parity, stop bits
  function automatic int unsigned frame_ticks(input logic [1:0] sel,
                                              input logic par,
                                              input logic two);
    return OS * (32'd2 + word_len(sel) + {31'd0, par} + {31'd0, two});
  endfunction

endpackage

// File: rtl/uart_rx_baud.sv
module uart_rx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  assign tick = (cnt >= div);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (clr || tick) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_s,
  output logic fall
);

  logic [SYNC_N-1:0] stage;
  logic              prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage <= '1;
      prev  <= 1'b1;
    end else begin
      stage <= {stage[SYNC_N-2:0], line_in};
      prev  <= stage[SYNC_N-1];
    end
  end

  assign line_s = stage[SYNC_N-1];
  assign fall   = prev & ~stage[SYNC_N-1];

endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          line_s,
  input  logic          fall,
  input  logic [1:0]    cfg_bits,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  input  logic          cfg_two_stop,
  output logic          start_evt,
  output logic          busy,
  output logic          deliver,
  output logic [DW-1:0] d_byte,
  output logic          d_ferr,
  output logic          d_perr
);

  rx_state_e     st;
  logic [3:0]    sc;
  logic [1:0]    win;
  logic [3:0]    bitcnt;
  logic [DW-1:0] shreg;
  logic          par_acc;
  logic          ferr_q;
  logic          perr_q;
  logic          stop_idx;
  logic [3:0]    len_w;
  logic          v;

  assign len_w     = 4'(word_len(cfg_bits));
  assign v         = vote3({win, line_s});
  assign busy      = (st != RX_IDLE);
  assign start_evt = (st == RX_IDLE) && fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= RX_IDLE;
      sc       <= '0;
      win      <= 2'b11;
      bitcnt   <= '0;
      shreg    <= '0;
      par_acc  <= 1'b0;
      ferr_q   <= 1'b0;
      perr_q   <= 1'b0;
      stop_idx <= 1'b0;
      deliver  <= 1'b0;
      d_byte   <= '0;
      d_ferr   <= 1'b0;
      d_perr   <= 1'b0;
    end else begin
      deliver <= 1'b0;
      if (start_evt) begin
        st       <= RX_START;
        sc       <= '0;
        bitcnt   <= '0;
        par_acc  <= 1'b0;
        ferr_q   <= 1'b0;
        perr_q   <= 1'b0;
        stop_idx <= 1'b0;
      end else if (busy && tick) begin
        win <= {win[0], line_s};
        sc  <= sc + 1'b1;
        if (sc == 4'(MID)) begin
          case (st)
            RX_START: st <= v ? RX_IDLE : RX_DATA;
            RX_DATA: begin
              shreg   <= {v, shreg[DW-1:1]};
              par_acc <= par_acc ^ v;
              bitcnt  <= bitcnt + 1'b1;
              if (bitcnt == len_w - 4'd1)
                st <= cfg_par_en ? RX_PAR : RX_STOP;
            end
            RX_PAR: begin
              perr_q <= ((par_acc ^ v) != cfg_par_odd);
              st     <= RX_STOP;
            end
            RX_STOP: begin
              if (cfg_two_stop && !stop_idx) begin
                stop_idx <= 1'b1;
                ferr_q   <= ferr_q | ~v;
              end else begin
                deliver <= 1'b1;
                d_byte  <= shreg >> (4'(DW) - len_w);
                d_ferr  <= ferr_q | ~v;
                d_perr  <= perr_q;
                st      <= RX_IDLE;
              end
            end
            default: st <= RX_IDLE;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          line_s,
  input  logic          busy,
  input  logic          deliver,
  input  logic [DW-1:0] d_byte,
  input  logic          d_ferr,
  input  logic          d_perr,
  input  logic          rd_ack,
  input  logic [1:0]    cfg_bits,
  input  logic          cfg_par_en,
  input  logic          cfg_two_stop,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  output logic          frame_err,
  output logic          parity_err,
  output logic          overrun,
  output logic          idle_pulse
);

  localparam int IW = $clog2(OS * (DW + 4) + 1);

  logic [IW-1:0] icnt;
  logic [IW-1:0] ftk;
  logic          armed;

  assign ftk = IW'(frame_ticks(cfg_bits, cfg_par_en, cfg_two_stop));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      frame_err  <= 1'b0;
      parity_err <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      if (deliver) begin
        rx_data    <= d_byte;
        rx_valid   <= 1'b1;
        frame_err  <= d_ferr;
        parity_err <= d_perr;
      end else if (rd_ack) begin
        rx_valid   <= 1'b0;
        frame_err  <= 1'b0;
        parity_err <= 1'b0;
      end
      if (deliver && rx_valid && !rd_ack) overrun <= 1'b1;
      else if (rd_ack)                    overrun <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      icnt       <= '0;
      armed      <= 1'b0;
      idle_pulse <= 1'b0;
    end else begin
      idle_pulse <= 1'b0;
      if (deliver) begin
        armed <= 1'b1;
        icnt  <= '0;
      end else if (busy || !line_s) begin
        icnt <= '0;
      end else if (armed && tick) begin
        if (icnt == ftk - 1'b1) begin
          idle_pulse <= 1'b1;
          armed      <= 1'b0;
          icnt       <= '0;
        end else begin
          icnt <= icnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx #(
  parameter int DIV_W  = 16,
  parameter int DW     = 8,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_line,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [1:0]       cfg_bits,
  input  logic             cfg_par_en,
  input  logic             cfg_par_odd,
  input  logic             cfg_two_stop,
  input  logic             rd_ack,
  output logic [DW-1:0]    rx_data,
  output logic             rx_valid,
  output logic             frame_err,
  output logic             parity_err,
  output logic             overrun,
  output logic             idle_pulse
);

  // named internal events, also observed by the checker
  logic          tick;
  logic          start_evt;
  logic          busy;
  logic          deliver;
  logic          rxs;
  logic          fall;
  logic [DW-1:0] d_byte;
  logic          d_ferr;
  logic          d_perr;

  uart_rx_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_in(rx_line), .line_s(rxs), .fall(fall)
  );

  uart_rx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .clr(start_evt), .div(cfg_div), .tick(tick)
  );

  uart_rx_frame #(.DW(DW)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line_s(rxs), .fall(fall),
    .cfg_bits(cfg_bits), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .start_evt(start_evt), .busy(busy),
    .deliver(deliver), .d_byte(d_byte), .d_ferr(d_ferr), .d_perr(d_perr)
  );

  uart_rx_status #(.DW(DW)) u_status (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line_s(rxs), .busy(busy),
    .deliver(deliver), .d_byte(d_byte), .d_ferr(d_ferr), .d_perr(d_perr),
    .rd_ack(rd_ack), .cfg_bits(cfg_bits), .cfg_par_en(cfg_par_en),
    .cfg_two_stop(cfg_two_stop), .rx_data(rx_data), .rx_valid(rx_valid),
    .frame_err(frame_err), .parity_err(parity_err), .overrun(overrun),
    .idle_pulse(idle_pulse)
  );

endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] cfg_div,
  input logic             rd_ack,
  input logic             rx_valid,
  input logic             overrun,
  input logic             idle_pulse,
  input logic             tick,
  input logic             start_evt,
  input logic             busy,
  input logic             deliver
);

  // R1
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_div != '0) && tick && !start_evt |=> (!tick || !$stable(cfg_div)));

  // R2
  start_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy);

  // R7
  valid_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deliver |=> rx_valid);

  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack && !deliver |=> !rx_valid);

  // R8
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deliver && rx_valid && !rd_ack |=> overrun);

  // R8
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !rd_ack |=> overrun);

  // R9
  idle_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_pulse |=> !idle_pulse);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_pulse |-> !busy);

endmodule

bind uart_os_rx uart_os_rx_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .rd_ack(rd_ack),
  .rx_valid(rx_valid), .overrun(overrun), .idle_pulse(idle_pulse),
  .tick(tick), .start_evt(start_evt), .busy(busy), .deliver(deliver)
);

// File: tb/uart_os_rx_test.sv
module uart_os_rx_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_line = 1'b1;
  logic [15:0] cfg_div = 16'd0;
  logic [1:0]  cfg_bits = 2'd3;
  logic        cfg_par_en = 1'b0;
  logic        cfg_par_odd = 1'b0;
  logic        cfg_two_stop = 1'b0;
  logic        rd_ack = 1'b0;
  logic [7:0]  rx_data;
  logic        rx_valid, frame_err, parity_err, overrun, idle_pulse;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int idle_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_os_rx uut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .cfg_div(cfg_div),
    .cfg_bits(cfg_bits), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .rd_ack(rd_ack), .rx_data(rx_data),
    .rx_valid(rx_valid), .frame_err(frame_err), .parity_err(parity_err),
    .overrun(overrun), .idle_pulse(idle_pulse)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && idle_pulse) idle_cnt <= idle_cnt + 1;
  end

  // expected values from the requirements
  function automatic int wlen();
    return 5 + int'(cfg_bits);
  endfunction
  function automatic logic [7:0] exp_data(input logic [7:0] d);
    return d & 8'((1 << wlen()) - 1);
  endfunction
  function automatic logic par_bit(input logic [7:0] d);
    return (^exp_data(d)) ^ cfg_par_odd;
  endfunction
  function automatic int tickp();
    return int'(cfg_div) + 1;
  endfunction
  function automatic int frame_len_ticks();
    return 16 * (1 + wlen() + int'(cfg_par_en) + (cfg_two_stop ? 2 : 1));
  endfunction

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  task automatic check(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input int n);
    rx_line = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input logic v, input bit disturb);
    int bp = 16 * tickp();
    if (disturb) begin
      drive(v, bp / 2 - 1);
      drive(~v, 2);
      drive(v, bp - bp / 2 - 1);
    end else begin
      drive(v, bp);
    end
  endtask

  task automatic send_frame(input logic [7:0] d, input bit bad_par,
                            input bit bad_stop, input bit disturb);
    int nst = cfg_two_stop ? 2 : 1;
    put_bit(1'b0, disturb);
    for (int i = 0; i < wlen(); i++) put_bit(d[i], disturb);
    if (cfg_par_en) put_bit(par_bit(d) ^ bad_par, disturb);
    for (int s = 0; s < nst; s++) put_bit(!(bad_stop && s == nst - 1), disturb);
    rx_line = 1'b1;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // one byte (or two, for overrun), its checks, read, and idle timing
  task automatic run_case(input string tag, input logic [7:0] d, input bit bad_par,
                          input bit bad_stop, input bit disturb, input bit ovr,
                          input int gap);
    int ic0 = idle_cnt;
    int tend;
    int ftk = frame_len_ticks();
    if (ovr) begin
      send_frame(~d, 1'b0, 1'b0, 1'b0);
      drive(1'b1, gap);
    end
    send_frame(d, bad_par, bad_stop, disturb);
    tend = cyc;
    repeat (3) @(negedge clk);
    check({tag, " R7 valid"}, int'(rx_valid), 1);
    check({tag, " data"}, int'(rx_data), int'(exp_data(d)));
    check("R5 parity flag", int'(parity_err), int'(cfg_par_en & bad_par));
    check("R6 framing flag", int'(frame_err), int'(bad_stop));
    check("R8 overrun flag", int'(overrun), int'(ovr));
    check("R9 no idle during traffic", idle_cnt, ic0);
    rd_ack = 1'b1;
    @(negedge clk);
    rd_ack = 1'b0;
    @(negedge clk);
    check("R7 valid cleared", int'(rx_valid), 0);
    check("R8 overrun cleared", int'(overrun), 0);
    check("R7 flags cleared", int'(frame_err | parity_err), 0);
    wait_until(tend + (ftk - 16) * tickp());
    check("R9 idle not early", idle_cnt, ic0);
    wait_until(tend + (ftk + 16) * tickp());
    check("R9 idle once", idle_cnt, ic0 + 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    void'($urandom(32'h5eed1));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 reset valid", int'(rx_valid), 0);
    check("R8 reset overrun", int'(overrun), 0);
    check("R6 reset flags", int'(frame_err | parity_err), 0);

    // R9: no idle event before any byte
    repeat (500) @(negedge clk);
    check("R9 no idle before byte", idle_cnt, 0);

    // R2: short low pulse is a glitch
    cfg_div = 16'd1;
    drive(1'b0, 8);
    drive(1'b1, 600);
    check("R2 glitch no byte", int'(rx_valid), 0);
    check("R2 glitch no idle", idle_cnt, 0);
    run_case("R2 after glitch", 8'hA5, 0, 0, 0, 0, 0);

    // R4: single-sample disturbance at every bit centre
    cfg_div = 16'd3;
    run_case("R4", 8'h5A, 0, 0, 1, 0, 0);

    // R3: shortest word, upper bits zero
    cfg_div = 16'd0; cfg_bits = 2'd0;
    run_case("R3 five-bit", 8'hFF, 0, 0, 0, 0, 0);

    // R5: even and odd parity, good and bad
    cfg_bits = 2'd3; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
    run_case("R5 even bad", 8'h37, 1, 0, 0, 0, 0);
    cfg_par_odd = 1'b1;
    run_case("R5 odd good", 8'h37, 0, 0, 0, 0, 0);

    // R6: two stop bits, second one low
    cfg_par_en = 1'b0; cfg_two_stop = 1'b1; cfg_div = 16'd2;
    run_case("R6 two-stop", 8'hC3, 0, 1, 0, 0, 0);

    // R10 and R8: back-to-back frames, unaligned gap, no read between
    cfg_two_stop = 1'b0; cfg_div = 16'd1;
    run_case("R10", 8'h96, 0, 0, 0, 1, 7);

    // R1: random configurations and divisors
    for (int it = 0; it < 36; it++) begin
      logic [7:0] d = 8'($urandom);
      bit bp, bs, ov;
      cfg_div      = 16'($urandom % 4);
      cfg_bits     = 2'($urandom);
      cfg_par_en   = 1'($urandom);
      cfg_par_odd  = 1'($urandom);
      cfg_two_stop = 1'($urandom);
      bp = ($urandom % 5) == 0;
      bs = ($urandom % 6) == 0;
      ov = ($urandom % 5) == 0;
      run_case("R1 random", d, bp, bs, 0, ov, int'($urandom % 23));
    end

    report();
  end

endmodule